// File: doc/BRIEF.md
# DMA Channel Run Controller

This block governs the run state of a single DMA channel. Software reaches it through a word-indexed register port with a write strobe, a write data word and a combinational readback word. There are four registers: a control and status word, a source address, a destination address and a remaining byte count. A simple data mover sits on the other side of the block. The block tells the mover when a transfer is in flight and which addresses to use. The mover answers with a one-cycle completion pulse, which may carry an error flag.

The channel has three states: halted, waiting and transferring. A start command moves a halted channel to waiting. From waiting, a transfer request launches one transfer of four bytes. Each clean completion advances both addresses and reduces the count. When the count runs out, the channel halts and reports normal completion. A completion that carries the error flag halts the channel and reports abnormal completion. A stop command parks a waiting channel. Because the addresses and the count are kept, the channel can later resume where it left off. Each completion kind has a sticky status bit and an interrupt line, and each interrupt line is gated by its own enable.

Top module: `dma_run_top`

## Requirements
- R1: After reset the channel is halted. Both enables, both status bits, both addresses and the count are 0, all four readback words are 0, and xferActive, irqNormal and irqAbort are 0.
- R2: Register word index 0 is control. Writing control with bit 31 = 1 while halted moves the channel to waiting. The state reads back in control bits 9:8 as 00 halted, 01 waiting and 10 transferring. A write with bit 31 = 0 and bit 24 = 0 changes no state. Bits 31 and 24 always read back as 0.
- R3: While waiting, xferReq high moves the channel to transferring at the next clock edge, and xferActive becomes 1.
- R4: A completion pulse (xferDone high, xferErr low) while transferring adds 4 to the source and destination addresses (word indexes 1 and 2). If the count (word index 3) was above 4, the count drops by 4 and the channel returns to waiting. Otherwise the count becomes 0, the channel halts and normal status (control bit 1) is set.
- R5: Writing control with bit 24 = 1 and bit 31 = 0 while waiting halts the channel, even if xferReq is high in the same cycle. The addresses and the count keep their values, and a later start resumes from them.
- R6: A stop write has no effect while halted or transferring. A transfer in flight runs to its completion.
- R7: A control write with both bit 31 and bit 24 set leaves the channel waiting, whether it was halted or waiting.
- R8: A completion pulse with xferErr high halts the channel and sets abort status (control bit 0). The addresses and the count stay unchanged.
- R9: Both status bits are sticky and are cleared by writing 1 to them in control bits 1 and 0. Writing 0 leaves them unchanged. A set in the same cycle as a clear wins.
- R10: irqNormal is normal status AND the normal enable (control bit 23). irqAbort is abort status AND the abort enable (control bit 22). Status is recorded even when the enable is 0.
- R11: The enables, the addresses and the count can be written only while halted. Writes to them in any other state are ignored.
- R12: A start while the count is 0 leaves the channel halted and sets normal status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word index (0 control, 1 source, 2 destination, 3 count) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Readback of the indexed register |
| xferReq | input | 1 | Transfer request from the requester |
| xferActive | output | 1 | High while a transfer is in flight to the mover |
| xferSrc | output | 32 | Current source address for the mover |
| xferDst | output | 32 | Current destination address for the mover |
| xferDone | input | 1 | One-cycle completion pulse from the mover |
| xferErr | input | 1 | Error flag, valid with xferDone |
| irqNormal | output | 1 | Normal-completion interrupt |
| irqAbort | output | 1 | Abnormal-completion interrupt |

## Verification
The hardest cases to reach from the ports are the ones where a register write lands in the same window as the mover handshake. One is a stop written while a transfer is in flight, which must not cut the transfer short. The other is a stop written in the same cycle as a rising request, where the stop must take priority. The bench uses a stub mover with a fixed three-cycle latency. It issues the stop write in the cycle after transferring begins, which is well before the completion pulse. It raises the request and the stop strobe on the same falling edge. The error path is reached by setting the stub's error flag, so that it arrives together with the completion pulse.

// File: rtl/dma_run_pkg.sv
package dma_run_pkg;

  typedef enum logic [1:0] {
    ST_HALT = 2'b00,
    ST_WAIT = 2'b01,
    ST_XFER = 2'b10
  } chState_t;

  typedef struct packed {
    logic loadSrc;
    logic loadDst;
    logic loadCnt;
    logic advance;
  } dpStrobe_t;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_SRC  = 2'd1;
  localparam logic [1:0] IDX_DST  = 2'd2;
  localparam logic [1:0] IDX_CNT  = 2'd3;

  localparam int BIT_START  = 31;
  localparam int BIT_STOP   = 24;
  localparam int BIT_NORMEN = 23;
  localparam int BIT_ABTEN  = 22;
  localparam int BIT_STLO   = 8;
  localparam int BIT_NSTAT  = 1;
  localparam int BIT_ASTAT  = 0;

endpackage

// File: rtl/dma_run_ctl.sv
module dma_run_ctl
  import dma_run_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic       startBit,
  input  logic       stopBit,
  input  logic       normEnBit,
  input  logic       abortEnBit,
  input  logic       clrNormBit,
  input  logic       clrAbortBit,
  input  logic       xferReq,
  input  logic       xferDone,
  input  logic       xferErr,
  input  logic       cntZero,
  input  logic       cntLast,
  output dpStrobe_t  strobe,
  output chState_t   stateQ,
  output logic       chHalted,
  output logic       normEn,
  output logic       abortEn,
  output logic       normStat,
  output logic       abortStat
);

  chState_t stateD;
  logic ctrlWr, startCmd, stopCmd;
  logic doneOk, doneBad, normSet, abortSet;

  assign ctrlWr   = regWe && (regAddr == IDX_CTRL);
  assign startCmd = ctrlWr && startBit;
  assign stopCmd  = ctrlWr && stopBit;
  assign chHalted = (stateQ == ST_HALT);

  assign doneOk  = (stateQ == ST_XFER) && xferDone && !xferErr;
  assign doneBad = (stateQ == ST_XFER) && xferDone && xferErr;

  assign strobe.loadSrc = chHalted && regWe && (regAddr == IDX_SRC);
  assign strobe.loadDst = chHalted && regWe && (regAddr == IDX_DST);
  assign strobe.loadCnt = chHalted && regWe && (regAddr == IDX_CNT);
  assign strobe.advance = doneOk;

  assign normSet  = (doneOk && cntLast) || (chHalted && startCmd && cntZero);
  assign abortSet = doneBad;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_HALT: if (startCmd && !cntZero) stateD = ST_WAIT;
      ST_WAIT: begin
        if (stopCmd && !startCmd) stateD = ST_HALT;
        else if (!stopCmd && xferReq) stateD = ST_XFER;
      end
      ST_XFER: begin
        if (doneBad) stateD = ST_HALT;
        else if (doneOk) stateD = cntLast ? ST_HALT : ST_WAIT;
      end
      default: stateD = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_HALT;
      normEn    <= 1'b0;
      abortEn   <= 1'b0;
      normStat  <= 1'b0;
      abortStat <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctrlWr && chHalted) begin
        normEn  <= normEnBit;
        abortEn <= abortEnBit;
      end
      normStat  <= normSet  | (normStat  & ~(ctrlWr & clrNormBit));
      abortStat <= abortSet | (abortStat & ~(ctrlWr & clrAbortBit));
    end
  end

  AST_XFER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_XFER && !xferDone) |=> (stateQ == ST_XFER)); // R6

  AST_STOP_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && stopCmd && !startCmd) |=> (stateQ == ST_HALT)); // R5

  AST_BOTH_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && startCmd && stopCmd) |=> (stateQ == ST_WAIT)); // R7

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_XFER && xferDone && xferErr) |=> (stateQ == ST_HALT && abortStat)); // R8

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (abortStat && !(ctrlWr && clrAbortBit)) |=> abortStat); // R9

  AST_EN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!chHalted) |=> (normEn == $past(normEn) && abortEn == $past(abortEn))); // R11

endmodule

// File: rtl/dma_run_dp.sv
module dma_run_dp
  import dma_run_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              chHalted,
  input  logic [DATA_W-1:0] wrAddrVal,
  input  logic [CNT_W-1:0]  wrCntVal,
  output logic [DATA_W-1:0] srcQ,
  output logic [DATA_W-1:0] dstQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic              cntZero,
  output logic              cntLast
);

  localparam logic [DATA_W-1:0] ADDR_STEP = DATA_W'(STEP);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(STEP);

  assign cntZero = (cntQ == '0);
  assign cntLast = (cntQ <= CNT_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
      cntQ <= '0;
    end else begin
      if (strobe.loadSrc) srcQ <= wrAddrVal;
      else if (strobe.advance) srcQ <= srcQ + ADDR_STEP;
      if (strobe.loadDst) dstQ <= wrAddrVal;
      else if (strobe.advance) dstQ <= dstQ + ADDR_STEP;
      if (strobe.loadCnt) cntQ <= wrCntVal;
      else if (strobe.advance) cntQ <= cntLast ? '0 : cntQ - CNT_STEP;
    end
  end

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (srcQ == $past(srcQ) + ADDR_STEP && dstQ == $past(dstQ) + ADDR_STEP)); // R4

  AST_LOAD_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadSrc || strobe.loadDst || strobe.loadCnt) |-> chHalted); // R11

  AST_CNT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.loadCnt) |=> $stable(cntQ)); // R5

endmodule

// File: rtl/dma_run_top.sv
module dma_run_top
  import dma_run_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              xferReq,
  output logic              xferActive,
  output logic [DATA_W-1:0] xferSrc,
  output logic [DATA_W-1:0] xferDst,
  input  logic              xferDone,
  input  logic              xferErr,
  output logic              irqNormal,
  output logic              irqAbort
);

  dpStrobe_t strobe;
  chState_t  stateQ;
  logic chHalted, normEn, abortEn, normStat, abortStat, cntZero, cntLast;
  logic [DATA_W-1:0] srcQ, dstQ, ctrlRd;
  logic [CNT_W-1:0]  cntQ;

  dma_run_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .startBit(regWdata[BIT_START]), .stopBit(regWdata[BIT_STOP]),
    .normEnBit(regWdata[BIT_NORMEN]), .abortEnBit(regWdata[BIT_ABTEN]),
    .clrNormBit(regWdata[BIT_NSTAT]), .clrAbortBit(regWdata[BIT_ASTAT]),
    .xferReq(xferReq), .xferDone(xferDone), .xferErr(xferErr),
    .cntZero(cntZero), .cntLast(cntLast), .strobe(strobe), .stateQ(stateQ),
    .chHalted(chHalted), .normEn(normEn), .abortEn(abortEn),
    .normStat(normStat), .abortStat(abortStat)
  );

  dma_run_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chHalted(chHalted),
    .wrAddrVal(regWdata), .wrCntVal(regWdata[CNT_W-1:0]),
    .srcQ(srcQ), .dstQ(dstQ), .cntQ(cntQ), .cntZero(cntZero), .cntLast(cntLast)
  );

  always_comb begin
    ctrlRd = '0;
    ctrlRd[BIT_NORMEN] = normEn;
    ctrlRd[BIT_ABTEN]  = abortEn;
    ctrlRd[BIT_STLO+1:BIT_STLO] = stateQ;
    ctrlRd[BIT_NSTAT]  = normStat;
    ctrlRd[BIT_ASTAT]  = abortStat;
  end

  always_comb begin
    unique case (regAddr)
      IDX_CTRL: regRdata = ctrlRd;
      IDX_SRC:  regRdata = srcQ;
      IDX_DST:  regRdata = dstQ;
      default:  regRdata = DATA_W'(cntQ);
    endcase
  end

  assign xferActive = (stateQ == ST_XFER);
  assign xferSrc    = srcQ;
  assign xferDst    = dstQ;
  assign irqNormal  = normStat & normEn;
  assign irqAbort   = abortStat & abortEn;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (irqNormal || irqAbort) |-> (normStat || abortStat)); // R10

endmodule

// File: tb/tb_dma_run_top.sv
module tb_dma_run_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        xferReq = 1'b0;
  logic        xferActive;
  logic [31:0] xferSrc, xferDst;
  logic        xferDone = 1'b0;
  logic        xferErr = 1'b0;
  logic        irqNormal, irqAbort;
  logic        injectErr = 1'b0;
  logic [3:0]  moverCnt = '0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  localparam int MOVER_LAT = 3;

  always #10 clk = ~clk;

  dma_run_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .xferReq(xferReq),
    .xferActive(xferActive), .xferSrc(xferSrc), .xferDst(xferDst),
    .xferDone(xferDone), .xferErr(xferErr), .irqNormal(irqNormal),
    .irqAbort(irqAbort)
  );

  // Stub mover: completes each transfer a fixed number of cycles after it starts.
  always @(posedge clk) begin
    xferDone <= 1'b0;
    xferErr  <= 1'b0;
    if (xferActive && !xferDone) begin
      if (moverCnt == 4'(MOVER_LAT - 1)) begin
        xferDone <= 1'b1;
        xferErr  <= injectErr;
        moverCnt <= '0;
      end else begin
        moverCnt <= moverCnt + 4'd1;
      end
    end
  end

  // {isRead, addr, data/expected}
  localparam logic [34:0] VEC [10] = '{
    {1'b0, 2'd1, 32'h0000_1000},
    {1'b1, 2'd1, 32'h0000_1000},
    {1'b0, 2'd2, 32'h0000_2000},
    {1'b1, 2'd2, 32'h0000_2000},
    {1'b0, 2'd3, 32'h0000_000C},
    {1'b1, 2'd3, 32'h0000_000C},
    {1'b0, 2'd0, 32'h00C0_0000},
    {1'b1, 2'd0, 32'h00C0_0000},
    {1'b0, 2'd0, 32'h00C0_0000},
    {1'b1, 2'd0, 32'h00C0_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic runXfer();
    @(negedge clk);
    xferReq = 1'b1;
    @(negedge clk);
    xferReq = 1'b0;
    while (xferActive) @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) rd("R1", 2'(i), 32'h0);
    check("R1", {29'd0, xferActive, irqNormal, irqAbort}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Table: writes and readbacks while halted (R11, R2)
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][34]) rd("R11", VEC[i][33:32], VEC[i][31:0]);
      else wr(VEC[i][33:32], VEC[i][31:0]);
    end

    // R2 start moves to waiting; start bit reads 0
    wr(2'd0, 32'h80C0_0000);
    rd("R2", 2'd0, 32'h00C0_0100);
    // R11 loads ignored while waiting
    wr(2'd1, 32'h0000_5555);
    rd("R11", 2'd1, 32'h0000_1000);
    wr(2'd0, 32'h0000_0000);
    rd("R11", 2'd0, 32'h00C0_0100);

    // R5 stop from waiting halts, keeps registers
    wr(2'd0, 32'h0100_0000);
    rd("R5", 2'd0, 32'h00C0_0000);
    rd("R5", 2'd3, 32'h0000_000C);
    // R6 stop while halted has no effect
    wr(2'd0, 32'h01C0_0000);
    rd("R6", 2'd0, 32'h00C0_0000);
    // R7 start+stop from halted, then again from waiting
    wr(2'd0, 32'h81C0_0000);
    rd("R7", 2'd0, 32'h00C0_0100);
    wr(2'd0, 32'h81C0_0000);
    rd("R7", 2'd0, 32'h00C0_0100);

    // R3 request starts a transfer; R6 stop during transfer is ignored
    @(negedge clk);
    xferReq = 1'b1;
    @(negedge clk);
    xferReq = 1'b0;
    check("R3", {31'd0, xferActive}, 32'h1);
    rd("R3", 2'd0, 32'h00C0_0200);
    wr(2'd0, 32'h0100_0000);
    rd("R6", 2'd0, 32'h00C0_0200);
    while (xferActive) @(negedge clk);
    rd("R6", 2'd0, 32'h00C0_0100);
    // R4 one step
    rd("R4", 2'd1, 32'h0000_1004);
    rd("R4", 2'd2, 32'h0000_2004);
    rd("R4", 2'd3, 32'h0000_0008);
    check("R4", xferSrc, 32'h0000_1004);

    // R5 park and resume
    wr(2'd0, 32'h0100_0000);
    rd("R5", 2'd1, 32'h0000_1004);
    rd("R5", 2'd3, 32'h0000_0008);
    wr(2'd0, 32'h80C0_0000);
    runXfer();
    rd("R5", 2'd3, 32'h0000_0004);
    rd("R5", 2'd0, 32'h00C0_0100);
    // R4 last transfer halts with normal status; R10 interrupt
    runXfer();
    rd("R4", 2'd0, 32'h00C0_0002);
    rd("R4", 2'd3, 32'h0000_0000);
    rd("R4", 2'd2, 32'h0000_200C);
    check("R10", {31'd0, irqNormal}, 32'h1);

    // R9 write-one clear
    wr(2'd0, 32'h00C0_0000);
    rd("R9", 2'd0, 32'h00C0_0002);
    wr(2'd0, 32'h00C0_0002);
    rd("R9", 2'd0, 32'h00C0_0000);
    check("R9", {31'd0, irqNormal}, 32'h0);

    // R12 start with zero count
    wr(2'd0, 32'h80C0_0000);
    rd("R12", 2'd0, 32'h00C0_0002);
    wr(2'd0, 32'h0000_0002);

    // R8 error completion; R10 gating by enable
    wr(2'd3, 32'h0000_0008);
    wr(2'd0, 32'h8000_0000);
    injectErr = 1'b1;
    runXfer();
    injectErr = 1'b0;
    rd("R8", 2'd0, 32'h0000_0001);
    rd("R8", 2'd1, 32'h0000_100C);
    rd("R8", 2'd3, 32'h0000_0008);
    check("R10", {31'd0, irqAbort}, 32'h0);
    wr(2'd0, 32'h0040_0000);
    rd("R9", 2'd0, 32'h0040_0001);
    check("R10", {31'd0, irqAbort}, 32'h1);
    wr(2'd0, 32'h0000_0001);

    // R5 stop wins over a request in the same cycle
    wr(2'd0, 32'h8000_0000);
    rd("R5", 2'd0, 32'h0000_0100);
    @(negedge clk);
    xferReq = 1'b1; regWe = 1'b1; regAddr = 2'd0; regWdata = 32'h0100_0000;
    @(negedge clk);
    xferReq = 1'b0; regWe = 1'b0; regWdata = '0;
    check("R5", {31'd0, xferActive}, 32'h0);
    rd("R5", 2'd0, 32'h0000_0000);
    rd("R5", 2'd3, 32'h0000_0008);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule